// File: doc/BRIEF.md
# Colour Sensor Conversion Sequencer

This block is the digital controller of a three-channel colour light sensor. A small register-write port loads two configuration bytes. The first byte selects an operating mode, a conversion resolution and a start source. The second byte holds an infrared compensation setting. From the mode code the sequencer decides which of the green, red and blue channels are converted, and in which rotation. It runs conversions back to back and latches each finished count into that channel's result register.

A pulse-counting integrator stands in for the analog front end. During a conversion window it counts the clock cycles in which `pulse_in` is high. The window lasts 2^HI_BITS cycles at full resolution and 2^LO_BITS cycles at reduced resolution. The count saturates at the top of the selected resolution. The shared interrupt/sync pin is split into an input, an output and an output enable. In interrupt mode the block drives a completion pulse on it. In sync mode the pin is an input, and a rising edge on it starts the conversion run.

Top module: `colour_seq`

## Requirements
- R1: After reset the mode is 000, `busy` is 0, all three results read 0, `int_oe` is 1, `int_out` is 0 and `ir_comp` is 0.
- R2: Mode codes 000 (power down) and 100 (standby) perform no conversion. `busy` stays 0 and the results do not change, whatever `pulse_in` does.
- R3: Mode codes 001, 010 and 011 convert only green, only red and only blue respectively, back to back, for as long as the mode is held.
- R4: Mode 101 converts green, then red, then blue, and wraps back to green. Mode 110 alternates green and red. Mode 111 alternates green and blue. Every new mode starts on its first listed channel.
- R5: With resolution bit 0 a conversion lasts 2^HI_BITS cycles, and with bit 1 it lasts 2^LO_BITS cycles. Sampling of `pulse_in` starts at the clock edge after the start edge. The result is the number of sampled high cycles, capped at 2^bits-1 for the selected resolution.
- R6: Only the channel just converted updates, and it updates in a single step at the end of its conversion. The other results keep their last value.
- R7: With the sync bit at 0, a configuration write that selects an active mode starts conversion at once. `int_oe` is 1, and `int_out` goes high for exactly the one cycle after each conversion ends.
- R8: With the sync bit at 1, `int_oe` and `int_out` are 0. No conversion happens until a rising edge on `sync_in` passes a two-flop synchroniser. The run then starts on the third clock edge after `sync_in` rises. Later edges during the run are ignored.
- R9: A configuration write aborts any conversion in progress. No partial result is written, and the sequencer restarts under the new settings.
- R10: `ir_comp` equals the 6-bit adjust field when the offset bit is 0, and equals adjust + 106 when the offset bit is 1. This gives a range of 0..63 or 106..169.
- R11: The configuration byte sits at address 1, with the mode in bits 2:0, resolution in bit 4 and sync in bit 5. The compensation byte sits at address 2, with adjust in bits 5:0 and offset in bit 7. A write to address 2 does not disturb a running conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| pulse_in | input | 1 | Stub front-end pulse, sampled each cycle |
| sync_in | input | 1 | Input side of the interrupt/sync pin |
| int_out | output | 1 | Output side of the interrupt/sync pin |
| int_oe | output | 1 | Output enable of the interrupt/sync pin |
| busy | output | 1 | A conversion run is active |
| ir_comp | output | 8 | Effective IR compensation value |
| res_green | output | HI_BITS | Green result |
| res_red | output | HI_BITS | Red result |
| res_blue | output | HI_BITS | Blue result |

## Verification
The assertions check on every cycle the relations that hold at any instant. Idle modes never run. A quiet pin never pulses. At most one result changes per cycle. A configuration write is never followed directly by a completion. Reduced-resolution results stay below their cap. The interrupt pulse always follows a completion. The compensation output stays within its two legal bands. Only the bench scenarios can show the channel rotation per mode, the exact window length and the pulse count, the abort that leaves no partial result, and the synchroniser latency. The bench checks these against its own model of pulse counts and channel order.

// File: rtl/colour_pkg.sv
package colour_pkg;

  typedef enum logic [1:0] {CH_GREEN = 2'd0, CH_RED = 2'd1, CH_BLUE = 2'd2} chan_e;

  localparam logic [1:0] ADDR_CFG  = 2'd1;
  localparam logic [1:0] ADDR_COMP = 2'd2;
  localparam logic [7:0] COMP_OFFSET = 8'd106;

  function automatic logic mode_active(input logic [2:0] m);
    return (m != 3'b000) && (m != 3'b100);
  endfunction

  function automatic chan_e first_chan(input logic [2:0] m);
    case (m)
      3'b010:  return CH_RED;
      3'b011:  return CH_BLUE;
      default: return CH_GREEN;
    endcase
  endfunction

  function automatic chan_e next_chan(input logic [2:0] m, input chan_e c);
    case (m)
      3'b101:  return (c == CH_GREEN) ? CH_RED : (c == CH_RED) ? CH_BLUE : CH_GREEN;
      3'b110:  return (c == CH_GREEN) ? CH_RED : CH_GREEN;
      3'b111:  return (c == CH_GREEN) ? CH_BLUE : CH_GREEN;
      default: return c;
    endcase
  endfunction

  function automatic logic [7:0] comp_value(input logic off, input logic [5:0] adj);
    return off ? ({2'b00, adj} + COMP_OFFSET) : {2'b00, adj};
  endfunction

endpackage

// File: rtl/sync_rise.sv
module sync_rise #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/pulse_integrator.sv
module pulse_integrator #(
  parameter int HI_BITS = 16,
  parameter int LO_BITS = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               run,
  input  logic               lo_res,
  input  logic               pulse_in,
  output logic               done,
  output logic [HI_BITS-1:0] value
);
  localparam logic [HI_BITS-1:0] LAST_HI = {HI_BITS{1'b1}};
  localparam logic [HI_BITS-1:0] LAST_LO = HI_BITS'((1 << LO_BITS) - 1);

  logic [HI_BITS-1:0] cnt;
  logic [HI_BITS:0]   acc, sum;

  function automatic logic [HI_BITS-1:0] clip(input logic [HI_BITS:0] s, input logic lo);
    logic [HI_BITS:0] cap;
    cap = lo ? {1'b0, LAST_LO} : {1'b0, LAST_HI};
    return (s > cap) ? cap[HI_BITS-1:0] : s[HI_BITS-1:0];
  endfunction

  assign done  = run && (cnt == (lo_res ? LAST_LO : LAST_HI));
  assign sum   = acc + {{HI_BITS{1'b0}}, pulse_in};
  assign value = clip(sum, lo_res);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      acc <= '0;
    end else if (clear || done) begin
      cnt <= '0;
      acc <= '0;
    end else if (run) begin
      cnt <= cnt + 1'b1;
      acc <= sum;
    end
  end
endmodule

// File: rtl/colour_seq.sv
module colour_seq
  import colour_pkg::*;
#(
  parameter int HI_BITS     = 16,
  parameter int LO_BITS     = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [7:0]         wr_data,
  input  logic               pulse_in,
  input  logic               sync_in,
  output logic               int_out,
  output logic               int_oe,
  output logic               busy,
  output logic [7:0]         ir_comp,
  output logic [HI_BITS-1:0] res_green,
  output logic [HI_BITS-1:0] res_red,
  output logic [HI_BITS-1:0] res_blue
);
  localparam int NCH = 3;

  logic [2:0] mode_q;
  logic       lo_q, sync_q, run_q, int_q, off_q;
  logic [5:0] adj_q;
  chan_e      chan_q;
  logic [HI_BITS-1:0] res_q [NCH];

  logic cfg_wr, comp_wr, sync_edge, start_evt, raw_done, conv_done;
  logic [HI_BITS-1:0] conv_val;
  logic unused_bits;

  assign cfg_wr      = wr_en && (wr_addr == ADDR_CFG);
  assign comp_wr     = wr_en && (wr_addr == ADDR_COMP);
  assign unused_bits = ^{wr_data[6], wr_data[3]};

  sync_rise #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(sync_in), .rise(sync_edge)
  );

  assign start_evt = sync_q && !run_q && sync_edge && mode_active(mode_q) && !cfg_wr;

  pulse_integrator #(.HI_BITS(HI_BITS), .LO_BITS(LO_BITS)) u_integ (
    .clk(clk), .rst_n(rst_n), .clear(cfg_wr), .run(run_q), .lo_res(lo_q),
    .pulse_in(pulse_in), .done(raw_done), .value(conv_val)
  );

  assign conv_done = raw_done && !cfg_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 3'b000;
      lo_q   <= 1'b0;
      sync_q <= 1'b0;
      run_q  <= 1'b0;
      chan_q <= CH_GREEN;
    end else if (cfg_wr) begin
      mode_q <= wr_data[2:0];
      lo_q   <= wr_data[4];
      sync_q <= wr_data[5];
      run_q  <= mode_active(wr_data[2:0]) && !wr_data[5];
      chan_q <= first_chan(wr_data[2:0]);
    end else begin
      if (start_evt) run_q <= 1'b1;
      if (conv_done) chan_q <= next_chan(mode_q, chan_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= 1'b0;
      adj_q <= '0;
    end else if (comp_wr) begin
      off_q <= wr_data[7];
      adj_q <= wr_data[5:0];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_res
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  res_q[c] <= '0;
      else if (conv_done && chan_q == chan_e'(c))  res_q[c] <= conv_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) int_q <= 1'b0;
    else        int_q <= conv_done && !sync_q;
  end

  assign int_oe    = !sync_q;
  assign int_out   = int_q && int_oe;
  assign busy      = run_q;
  assign ir_comp   = comp_value(off_q, adj_q);
  assign res_green = res_q[0];
  assign res_red   = res_q[1];
  assign res_blue  = res_q[2];
endmodule

// File: rtl/colour_seq_chk.sv
module colour_seq_chk #(
  parameter int HI_BITS = 16,
  parameter int LO_BITS = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         mode,
  input logic               lo_res,
  input logic               cfg_wr,
  input logic               conv_done,
  input logic               busy,
  input logic               int_oe,
  input logic               int_out,
  input logic [7:0]         ir_comp,
  input logic [HI_BITS-1:0] res_g,
  input logic [HI_BITS-1:0] res_r,
  input logic [HI_BITS-1:0] res_b
);
  localparam logic [HI_BITS-1:0] LO_CAP = HI_BITS'((1 << LO_BITS) - 1);

  AST_IDLE_NO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b000 || mode == 3'b100) |-> !busy); // R2
  AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !int_oe |-> !int_out); // R8
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({res_g != $past(res_g), res_r != $past(res_r), res_b != $past(res_b)})); // R6
  AST_ABORT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !conv_done); // R9
  AST_LO_CAP_G: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_res && res_g != $past(res_g)) |-> res_g <= LO_CAP); // R5
  AST_LO_CAP_R: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_res && res_r != $past(res_r)) |-> res_r <= LO_CAP); // R5
  AST_LO_CAP_B: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_res && res_b != $past(res_b)) |-> res_b <= LO_CAP); // R5
  AST_INT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> $past(conv_done)); // R7
  AST_COMP_BANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_comp <= 8'd63) || (ir_comp >= 8'd106 && ir_comp <= 8'd169)); // R10
endmodule

bind colour_seq colour_seq_chk #(.HI_BITS(HI_BITS), .LO_BITS(LO_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode_q), .lo_res(lo_q), .cfg_wr(cfg_wr),
  .conv_done(conv_done), .busy(busy), .int_oe(int_oe), .int_out(int_out),
  .ir_comp(ir_comp), .res_g(res_green), .res_r(res_red), .res_b(res_blue)
);

// File: tb/test_colour_seq.sv
module test_colour_seq;
  localparam int CLK_PERIOD = 10;
  localparam int HI = 6;
  localparam int LO = 4;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, pulse_in = 1'b0, sync_in = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic int_out, int_oe, busy;
  logic [7:0] ir_comp;
  logic [HI-1:0] res_green, res_red, res_blue;

  colour_seq #(.HI_BITS(HI), .LO_BITS(LO)) i_colour_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pulse_in(pulse_in), .sync_in(sync_in), .int_out(int_out), .int_oe(int_oe),
    .busy(busy), .ir_comp(ir_comp), .res_green(res_green), .res_red(res_red),
    .res_blue(res_blue)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  int exp_res [3];
  int ch;
  logic [2:0] cur_mode;
  bit cur_lo, cur_sync;

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int b_first(input logic [2:0] m);
    if (m == 3'd2) return 1;
    if (m == 3'd3) return 2;
    return 0;
  endfunction

  function automatic int b_next(input logic [2:0] m, input int c);
    if (m == 3'd5) return (c + 1) % 3;
    if (m == 3'd6) return (c == 0) ? 1 : 0;
    if (m == 3'd7) return (c == 0) ? 2 : 0;
    return c;
  endfunction

  function automatic int b_len(input bit lo);
    return lo ? (1 << LO) : (1 << HI);
  endfunction

  function automatic int b_comp(input logic [7:0] d);
    return d[7] ? (int'(d[5:0]) + 106) : int'(d[5:0]);
  endfunction

  task automatic check_results(string req);
    chk((ch == 0) ? req : "R6", int'(res_green), exp_res[0], "green");
    chk((ch == 1) ? req : "R6", int'(res_red),   exp_res[1], "red");
    chk((ch == 2) ? req : "R6", int'(res_blue),  exp_res[2], "blue");
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d; pulse_in = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_cfg(input logic [2:0] m, input bit lo, input bit sy);
    wr(2'd1, {2'b00, sy, lo, 1'b0, m});
    cur_mode = m; cur_lo = lo; cur_sync = sy;
    ch = b_first(m);
  endtask

  task automatic run_convs(input int n, input int pct, input string req, input int pre);
    for (int k = 0; k < n; k++) begin
      int cnt = 0;
      int cap = b_len(cur_lo) - 1;
      for (int i = (k == 0) ? pre : 0; i < b_len(cur_lo); i++) begin
        bit p = (($urandom % 100) < pct);
        cnt += p;
        pulse_in = p;
        @(negedge clk);
      end
      pulse_in = 1'b0;
      exp_res[ch] = (cnt > cap) ? cap : cnt;
      check_results(req);
      chk(cur_sync ? "R8" : "R7", int'(int_out), cur_sync ? 0 : 1, "int_out at end");
      ch = b_next(cur_mode, ch);
    end
  endtask

  task automatic idle_cycles(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      pulse_in = 1'b1;
      @(negedge clk);
    end
    pulse_in = 1'b0;
    chk(req, int'(busy), 0, "busy while idle");
    check_results(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] modes [6];
    modes = '{3'd1, 3'd2, 3'd3, 3'd5, 3'd6, 3'd7};
    void'($urandom(32'd2024));
    exp_res = '{0, 0, 0};
    ch = 0; cur_mode = 0; cur_lo = 0; cur_sync = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", int'(busy), 0, "busy");
    chk("R1", int'(int_oe), 1, "int_oe");
    chk("R1", int'(int_out), 0, "int_out");
    chk("R1", int'(ir_comp), 0, "ir_comp");
    check_results("R1");

    // R2 power down and standby
    idle_cycles(20, "R2");
    set_cfg(3'd4, 1'b0, 1'b0);
    idle_cycles(20, "R2");

    // R3 single channels, R5 saturation at both resolutions
    set_cfg(3'd1, 1'b0, 1'b0);
    run_convs(2, 50, "R3", 0);
    run_convs(1, 100, "R5", 0);
    set_cfg(3'd2, 1'b1, 1'b0);
    run_convs(2, 100, "R5", 0);
    set_cfg(3'd3, 1'b1, 1'b0);
    run_convs(2, 30, "R3", 0);

    // R4 rotations
    set_cfg(3'd5, 1'b0, 1'b0);
    run_convs(4, 40, "R4", 0);
    set_cfg(3'd6, 1'b1, 1'b0);
    run_convs(3, 60, "R4", 0);
    set_cfg(3'd7, 1'b1, 1'b0);
    run_convs(3, 70, "R4", 0);

    // R9 abort mid conversion
    set_cfg(3'd5, 1'b0, 1'b0);
    for (int i = 0; i < 30; i++) begin pulse_in = 1'b1; @(negedge clk); end
    set_cfg(3'd3, 1'b1, 1'b0);
    check_results("R9");
    run_convs(1, 50, "R9", 0);

    // R10 and R11 compensation, write during a conversion
    set_cfg(3'd1, 1'b1, 1'b0);
    wr(2'd2, 8'h3F);
    chk("R10", int'(ir_comp), 63, "comp max low band");
    run_convs(1, 50, "R11", 1);
    wr(2'd2, 8'h80);
    chk("R10", int'(ir_comp), 106, "comp min high band");
    run_convs(1, 50, "R11", 1);
    wr(2'd2, 8'hBF);
    chk("R10", int'(ir_comp), 169, "comp max high band");
    run_convs(1, 50, "R11", 1);

    // R8 sync start
    set_cfg(3'd5, 1'b0, 1'b1);
    chk("R8", int'(int_oe), 0, "int_oe in sync mode");
    idle_cycles(10, "R8");
    sync_in = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R8", int'(busy), 0, "busy before synchroniser");
    @(negedge clk);
    chk("R8", int'(busy), 1, "busy after synchroniser");
    run_convs(1, 60, "R8", 0);
    sync_in = 1'b0;
    run_convs(1, 60, "R8", 0);
    sync_in = 1'b1;
    run_convs(2, 60, "R8", 0);
    sync_in = 1'b0;

    // R7 and R4 randomized
    for (int it = 0; it < 8; it++) begin
      logic [7:0] cv = 8'($urandom);
      set_cfg(modes[$urandom % 6], 1'($urandom), 1'b0);
      chk("R7", int'(int_oe), 1, "int_oe after write");
      wr(2'd2, cv);
      chk("R10", int'(ir_comp), b_comp(cv), "comp random");
      run_convs(1 + int'($urandom % 3), int'($urandom % 101), "R4", 1);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule